// File: doc/BRIEF.md
# Fuse and Lock Byte Write Sequencer

This block sits on the host side of a parallel programming link and writes one configuration byte into a target device. The byte can go to the low fuse byte, the high fuse byte or the lock byte. A single start pulse captures a target selector, the byte value and a wait-mode bit. The block then clocks a command byte and the value into the target with two load strobes. It selects the destination byte through two select lines and drives a low-going write strobe. It then waits for the target's ready/busy line to return high.

All pin timing is counted in system clock cycles. The counts are derived at elaboration from a clock-frequency parameter and fixed nanosecond minimums, rounded up. After the write strobe, the block ignores the ready line for a blanking window, so the level seen before the target goes busy is not taken as completion. A completion timer runs from the strobe's falling edge. One of two elaboration-time limits applies: a normal limit for fuse and lock writes, and a longer one selected by the wait-mode bit. If the timer runs out, the block reports an error instead of completion.

Top module: `fuselock_writer`

## Requirements
- R1: After reset, strobe_n is 1, load_clk is 0, addr_mode is 2'b00, byte_sel is 2'b00, data_oe is 0, and busy, done and err are 0.
- R2: Each operation produces exactly two load_clk rising edges. At the first, addr_mode is 2'b10 and data_out carries the command: 8'h40 for target 2'b00 or 2'b01, and 8'h20 for target 2'b10 or 2'b11. At the second, addr_mode is 2'b01 and data_out carries the captured value unchanged (a 0 bit programs, a 1 bit erases).
- R3: addr_mode and data_out stay stable for at least ceil(67 ns) in cycles before each load_clk rise. load_clk stays high for at least ceil(150 ns) in cycles. load_clk is never high while strobe_n is low.
- R4: During the write strobe, byte_sel (bit 0 is the low select line, bit 1 the high select line) is 2'b00 for the low fuse byte (target 2'b00), 2'b01 for the high fuse byte (target 2'b01), and 2'b00 for the lock byte (target 2'b1x).
- R5: byte_sel settles at least ceil(67 ns) in cycles before strobe_n falls and does not change while strobe_n is low. strobe_n stays low for at least ceil(150 ns) in cycles.
- R6: A high level on tgt_ready within ceil(1000 ns) in cycles after the end of the strobe hold window is never taken as completion. Completion waits for tgt_ready to go low and come back high.
- R7: Once tgt_ready returns high after the blanking window, done pulses for one cycle no more than 4 cycles later. busy then drops and byte_sel returns to 2'b00. done and err never assert together.
- R8: If tgt_ready is not seen high by the time the limit expires, err pulses for one cycle instead of done. The limit is TMO_SHORT_US when long_wait was 0 at start and TMO_LONG_US when it was 1. err appears between limit and limit+3 cycles after strobe_n falls.
- R9: start is ignored while busy is 1. The target, value and wait mode captured at the accepted start stay in force for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| target | input | 2 | 00 low fuse byte, 01 high fuse byte, 1x lock byte |
| value | input | 8 | Byte to write |
| long_wait | input | 1 | Select the long completion limit |
| tgt_ready | input | 1 | Target ready/busy line, asynchronous |
| addr_mode | output | 2 | Load-type code: 10 command, 01 data low byte |
| byte_sel | output | 2 | Destination byte select lines |
| load_clk | output | 1 | Load strobe toward the target |
| strobe_n | output | 1 | Active-low write strobe |
| data_out | output | 8 | Byte driven onto the data bus |
| data_oe | output | 1 | Data bus drive enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |

## Verification
The bench builds the block at 50 MHz. The 67, 150, 200 and 1000 ns minimums therefore round to 4, 8, 10 and 50 cycles, which lets the pin-level windows be checked at exact cycle counts. The two completion limits are shrunk to 20 µs and 60 µs (1000 and 3000 cycles), so the short-limit error, the long-limit success and the long-limit error all fit within one run. A target model drops and raises tgt_ready at chosen offsets from the strobe. A drop late inside the 1 µs window shows that the blanking really suppresses the idle-high level.

// File: rtl/fl_pkg.sv
package fl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_SETUP, ST_CLKHI, ST_CLKLO,
      ST_BANK, ST_STROBE, ST_HOLD, ST_BLANK, ST_WAIT
   } fl_state_e;

   localparam logic [7:0] CMD_FUSE  = 8'h40;
   localparam logic [7:0] CMD_LOCK  = 8'h20;
   localparam logic [1:0] MODE_NONE = 2'b00;
   localparam logic [1:0] MODE_DATA = 2'b01;
   localparam logic [1:0] MODE_CMD  = 2'b10;

   // Round a nanosecond minimum up to whole clock cycles, never below one.
   function automatic int ns_to_cyc(input longint clk_hz, input longint ns);
      longint r;
      r = (ns * clk_hz + 64'sd999_999_999) / 64'sd1_000_000_000;
      return (r < 1) ? 1 : int'(r);
   endfunction

   function automatic logic [7:0] cmd_for(input logic [1:0] t);
      return t[1] ? CMD_LOCK : CMD_FUSE;
   endfunction

   function automatic logic [1:0] sel_for(input logic [1:0] t);
      return (t == 2'b01) ? 2'b01 : 2'b00;
   endfunction

endpackage

// File: rtl/fl_sync.sv
module fl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/fl_phase.sv
module fl_phase #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= len - W'(1);
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/fl_watch.sv
module fl_watch #(
   parameter int SHORT_CYC = 1000,
   parameter int LONG_CYC  = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic long_sel,
   output logic expired
);
   localparam int W = $clog2(LONG_CYC + 1);

   generate
      if (LONG_CYC < SHORT_CYC) begin : g_bad_limits
         $error("fl_watch: LONG_CYC must not be below SHORT_CYC");
      end
   endgenerate

   logic [W-1:0] cnt;
   logic [W-1:0] lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lim <= '0;
      end else if (arm) begin
         cnt <= '0;
         lim <= long_sel ? W'(LONG_CYC) : W'(SHORT_CYC);
      end else if (cnt != lim) begin
         cnt <= cnt + W'(1);
      end
   end

   assign expired = (cnt == lim);

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);
endmodule

// File: rtl/fuselock_writer.sv
module fuselock_writer
   import fl_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 50_000_000,
   parameter int unsigned TMO_SHORT_US = 4600,
   parameter int unsigned TMO_LONG_US  = 9200,
   parameter int          SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] target,
   input  logic [7:0] value,
   input  logic       long_wait,
   input  logic       tgt_ready,
   output logic [1:0] addr_mode,
   output logic [1:0] byte_sel,
   output logic       load_clk,
   output logic       strobe_n,
   output logic [7:0] data_out,
   output logic       data_oe,
   output logic       busy,
   output logic       done,
   output logic       err
);
   localparam int SET_CYC   = ns_to_cyc(longint'(CLK_HZ), 67);
   localparam int PULSE_CYC = ns_to_cyc(longint'(CLK_HZ), 150);
   localparam int GAP_CYC   = ns_to_cyc(longint'(CLK_HZ), 200);
   localparam int BLANK_CYC = ns_to_cyc(longint'(CLK_HZ), 1000);
   localparam int LO_CYC    = (GAP_CYC > 2 * SET_CYC) ? GAP_CYC - SET_CYC : SET_CYC;
   localparam int SHORT_CYC = int'(longint'(TMO_SHORT_US) * longint'(CLK_HZ) / 64'sd1_000_000);
   localparam int LONG_CYC  = int'(longint'(TMO_LONG_US) * longint'(CLK_HZ) / 64'sd1_000_000);
   localparam int PH_MAX    = BLANK_CYC + PULSE_CYC + LO_CYC + SET_CYC;
   localparam int PW        = $clog2(PH_MAX + 1) + 1;

   generate
      if (SHORT_CYC <= PULSE_CYC + SET_CYC + BLANK_CYC) begin : g_bad_tmo
         $error("fuselock_writer: short limit shorter than strobe plus blanking");
      end
   endgenerate

   fl_state_e    st_q, st_d;
   logic         second_q, second_d;
   logic [1:0]   tgt_q, tgt_d;
   logic [7:0]   val_q, val_d;
   logic         long_q;
   logic         ph_load, ph_zero;
   logic [PW-1:0] ph_len;
   logic         arm, expired, rdy_s;
   logic         fin_ok, fin_bad;

   fl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(tgt_ready), .q(rdy_s));

   fl_phase #(.W(PW)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .len(ph_len), .zero(ph_zero));

   fl_watch #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_watch (
      .clk(clk), .rst_n(rst_n), .arm(arm), .long_sel(long_q), .expired(expired));

   wire accept = (st_q == ST_IDLE) && start;
   assign tgt_d = accept ? target : tgt_q;
   assign val_d = accept ? value  : val_q;

   always_comb begin
      st_d     = st_q;
      second_d = second_q;
      ph_load  = 1'b0;
      ph_len   = PW'(SET_CYC);
      arm      = 1'b0;
      fin_ok   = 1'b0;
      fin_bad  = 1'b0;
      case (st_q)
         ST_IDLE:   if (start) begin
                       st_d = ST_SETUP; second_d = 1'b0; ph_load = 1'b1;
                    end
         ST_SETUP:  if (ph_zero) begin
                       st_d = ST_CLKHI; ph_load = 1'b1; ph_len = PW'(PULSE_CYC);
                    end
         ST_CLKHI:  if (ph_zero) begin
                       st_d = ST_CLKLO; ph_load = 1'b1; ph_len = PW'(LO_CYC);
                    end
         ST_CLKLO:  if (ph_zero) begin
                       ph_load = 1'b1;
                       if (!second_q) begin
                          st_d = ST_SETUP; second_d = 1'b1;
                       end else begin
                          st_d = ST_BANK;
                       end
                    end
         ST_BANK:   if (ph_zero) begin
                       st_d = ST_STROBE; ph_load = 1'b1; ph_len = PW'(PULSE_CYC); arm = 1'b1;
                    end
         ST_STROBE: if (ph_zero) begin
                       st_d = ST_HOLD; ph_load = 1'b1;
                    end
         ST_HOLD:   if (ph_zero) begin
                       st_d = ST_BLANK; ph_load = 1'b1; ph_len = PW'(BLANK_CYC);
                    end
         ST_BLANK:  if (ph_zero) st_d = ST_WAIT;
         ST_WAIT:   if (rdy_s) begin
                       st_d = ST_IDLE; fin_ok = 1'b1;
                    end else if (expired) begin
                       st_d = ST_IDLE; fin_bad = 1'b1;
                    end
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         second_q <= 1'b0;
         tgt_q    <= 2'b00;
         val_q    <= 8'h00;
         long_q   <= 1'b0;
      end else begin
         st_q     <= st_d;
         second_q <= second_d;
         tgt_q    <= tgt_d;
         val_q    <= val_d;
         if (accept) long_q <= long_wait;
      end
   end

   // Pin outputs are registered from the next-state decode so they leave flops cleanly.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_mode <= MODE_NONE;
         byte_sel  <= 2'b00;
         load_clk  <= 1'b0;
         strobe_n  <= 1'b1;
         data_out  <= 8'h00;
         data_oe   <= 1'b0;
         busy      <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         addr_mode <= MODE_NONE;
         byte_sel  <= 2'b00;
         load_clk  <= 1'b0;
         strobe_n  <= 1'b1;
         data_out  <= 8'h00;
         data_oe   <= 1'b0;
         busy      <= (st_d != ST_IDLE);
         done      <= fin_ok;
         err       <= fin_bad;
         case (st_d)
            ST_SETUP, ST_CLKHI, ST_CLKLO: begin
               data_oe   <= 1'b1;
               addr_mode <= second_d ? MODE_DATA : MODE_CMD;
               data_out  <= second_d ? val_d : cmd_for(tgt_d);
               load_clk  <= (st_d == ST_CLKHI);
            end
            ST_BANK, ST_STROBE, ST_HOLD, ST_BLANK, ST_WAIT: begin
               data_oe  <= 1'b1;
               data_out <= val_d;
               byte_sel <= sel_for(tgt_d);
               strobe_n <= (st_d != ST_STROBE);
            end
            default: ;
         endcase
      end
   end

   assert_sel_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_n && $past(!strobe_n)) |-> $stable(byte_sel));
   assert_no_load_in_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_clk && !strobe_n));
   assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
   assert_done_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rdy_s));
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(tgt_q) && $stable(val_q));
endmodule

// File: tb/sim_fuselock_writer.sv
`timescale 1ns/1ps
module sim_fuselock_writer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] target = 2'b00;
   logic [7:0] value = 8'h00;
   logic       long_wait = 1'b0;
   logic       tgt_ready = 1'b1;
   logic [1:0] addr_mode, byte_sel;
   logic       load_clk, strobe_n, data_oe, busy, done, err;
   logic [7:0] data_out;

   localparam int SHORT_LIM = 1000;
   localparam int LONG_LIM  = 3000;

   fuselock_writer #(.CLK_HZ(50_000_000), .TMO_SHORT_US(20), .TMO_LONG_US(60)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .target(target), .value(value),
      .long_wait(long_wait), .tgt_ready(tgt_ready), .addr_mode(addr_mode),
      .byte_sel(byte_sel), .load_clk(load_clk), .strobe_n(strobe_n),
      .data_out(data_out), .data_oe(data_oe), .busy(busy), .done(done), .err(err));

   always #10 clk = ~clk;

   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Pin monitor, sampled on the falling clock edge.
   int n_ld = 0, n_done = 0, n_err = 0;
   int ld_mode[8], ld_data[8], ld_setup[8], ld_width[8];
   int stab = 0, selstab = 0, hi_run = 0, lo_run = 0;
   int sel_at_fall = 0, sel_setup = 0, st_width = 0;
   logic [9:0] prev_md = '0;
   logic [1:0] prev_sel = '0;
   logic prev_lclk = 1'b0, prev_strb = 1'b1;

   always @(negedge clk) begin
      if ({addr_mode, data_out} != prev_md) stab = 0; else stab++;
      if (byte_sel != prev_sel) selstab = 0; else selstab++;
      if (load_clk && !prev_lclk) begin
         if (n_ld < 8) begin
            ld_mode[n_ld] = int'(addr_mode);
            ld_data[n_ld] = int'(data_out);
            ld_setup[n_ld] = stab;
         end
         n_ld++;
         hi_run = 0;
      end
      if (load_clk) hi_run++;
      if (!load_clk && prev_lclk && n_ld > 0 && n_ld <= 8) ld_width[n_ld-1] = hi_run;
      if (!strobe_n && prev_strb) begin
         sel_at_fall = int'(byte_sel);
         sel_setup = selstab;
         lo_run = 0;
      end
      if (!strobe_n) lo_run++;
      if (strobe_n && !prev_strb) st_width = lo_run;
      if (done) n_done++;
      if (err) n_err++;
      prev_md = {addr_mode, data_out};
      prev_sel = byte_sel;
      prev_lclk = load_clk;
      prev_strb = strobe_n;
   end

   task automatic check_reset();
      @(negedge clk);
      chk(strobe_n == 1'b1 && load_clk == 1'b0, "R1", "strobes idle", {strobe_n, load_clk}, 2'b10);
      chk(addr_mode == 2'b00 && byte_sel == 2'b00, "R1", "mode/sel idle", {addr_mode, byte_sel}, 0);
      chk(!data_oe && !busy && !done && !err, "R1", "flags idle", {data_oe, busy, done, err}, 0);
   endtask

   // One write: ready drops fdly cycles after the strobe falls, rises at rdly (0 = never).
   task automatic run_op(input logic [1:0] tgt, input logic [7:0] val, input bit lw,
                         input int fdly, input int rdly, input bit poke,
                         input bit exp_done, input int lim);
      int k;
      int d0, e0;
      int exp_cmd, exp_sel;
      bit got_done, got_err;
      exp_cmd = tgt[1] ? 8'h20 : 8'h40;
      exp_sel = (tgt == 2'b01) ? 1 : 0;
      n_ld = 0;
      d0 = n_done;
      e0 = n_err;
      @(negedge clk);
      start = 1'b1; target = tgt; value = val; long_wait = lw;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         start = 1'b1; target = ~tgt; value = ~val; long_wait = ~lw;
         @(negedge clk);
         start = 1'b0;
      end
      while (strobe_n) @(negedge clk);
      k = 0;
      got_done = 1'b0;
      got_err = 1'b0;
      while (k < 20000) begin
         @(negedge clk);
         k++;
         if (k == fdly) tgt_ready = 1'b0;
         if (rdly != 0 && k == rdly) tgt_ready = 1'b1;
         if (done) got_done = 1'b1;
         if (err) got_err = 1'b1;
         if (got_done || got_err) break;
      end
      tgt_ready = 1'b1;
      @(negedge clk);
      chk(!busy && byte_sel == 2'b00, "R7", "idle after end", {busy, byte_sel}, 0);
      repeat (10) @(negedge clk);
      chk(n_ld == 2, "R2", "load count", n_ld, 2);
      chk(ld_mode[0] == 2 && ld_data[0] == exp_cmd, "R2", "command load",
          (ld_mode[0] << 8) | ld_data[0], (2 << 8) | exp_cmd);
      chk(ld_mode[1] == 1 && ld_data[1] == int'(val), "R2", "value load",
          (ld_mode[1] << 8) | ld_data[1], (1 << 8) | int'(val));
      chk(ld_setup[0] >= 4 && ld_setup[1] >= 4, "R3", "load setup", ld_setup[1], 4);
      chk(ld_width[0] >= 8 && ld_width[1] >= 8, "R3", "load width", ld_width[1], 8);
      chk(sel_at_fall == exp_sel, "R4", "byte_sel at strobe", sel_at_fall, exp_sel);
      chk(sel_setup >= 4 && st_width >= 8, "R5", "sel setup/strobe width",
          (sel_setup << 8) | st_width, (4 << 8) | 8);
      if (exp_done) begin
         chk(got_done && !got_err && k > rdly && k <= rdly + 4, "R7", "done timing", k, rdly + 3);
      end else begin
         chk(got_err && !got_done && k >= lim && k <= lim + 3, "R8", "timeout timing", k, lim + 1);
      end
      chk(n_done - d0 == (exp_done ? 1 : 0) && n_err - e0 == (exp_done ? 0 : 1), "R9",
          "single outcome", ((n_done - d0) << 4) | (n_err - e0), exp_done ? 16 : 1);
   endtask

   task automatic t_fuse_low();   run_op(2'b00, 8'hA5, 1'b0, 20, 300, 1'b0, 1'b1, 0); endtask // R2 R4 R7
   task automatic t_fuse_high();  run_op(2'b01, 8'h3C, 1'b0, 20, 300, 1'b0, 1'b1, 0); endtask // R4
   task automatic t_lock();       run_op(2'b10, 8'hFC, 1'b0, 10, 200, 1'b0, 1'b1, 0); endtask // R2 R4
   task automatic t_lock_alias(); run_op(2'b11, 8'h00, 1'b0, 10, 200, 1'b0, 1'b1, 0); endtask // R4
   task automatic t_blanking();   run_op(2'b00, 8'h5A, 1'b0, 45, 400, 1'b0, 1'b1, 0); endtask // R6
   task automatic t_tmo_short();  run_op(2'b01, 8'hFF, 1'b0, 20, 0, 1'b0, 1'b0, SHORT_LIM); endtask // R8
   task automatic t_long_ok();    run_op(2'b00, 8'h81, 1'b1, 20, 1500, 1'b0, 1'b1, 0); endtask // R8
   task automatic t_long_tmo();   run_op(2'b10, 8'h7E, 1'b1, 20, 0, 1'b0, 1'b0, LONG_LIM); endtask // R8
   task automatic t_short_vs_long(); run_op(2'b00, 8'h81, 1'b0, 20, 1500, 1'b0, 1'b0, SHORT_LIM); endtask // R8
   task automatic t_busy_start(); run_op(2'b10, 8'hC3, 1'b0, 20, 300, 1'b1, 1'b1, 0); endtask // R9

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      check_reset();
      t_fuse_low();
      t_fuse_high();
      t_lock();
      t_lock_alias();
      t_blanking();
      t_tmo_short();
      t_long_ok();
      t_long_tmo();
      t_short_vs_long();
      t_busy_start();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule